// File: doc/BRIEF.md
# Descriptor Ring Cache Engine

This block holds a small on-chip cache of DMA descriptors drawn from a circular ring in host memory. Software programs the ring length, the hardware head and the tail. From these the engine works out how many descriptors it may fetch and how many completed ones it may write back. It issues one fetch request and one writeback request at a time, each with a start index and a count. It tracks the fetch pointer, the hardware head, and the numbers of unused (fetched, not yet consumed) and used (completed, not yet written back) cache entries.

The datapath pulses a completion strobe each time it finishes with a descriptor. The memory side returns a one-cycle acknowledge when a request has been served. A writeback can be limited to whole aligned groups through a mask. It is clipped at the end of the ring, and the remainder then follows by itself. Reprogramming the ring while the engine holds work is refused and flagged.

Top module: `desc_ring_engine`

## Requirements
- R1: After reset, fetch_req, wb_req, head_upd and ring_err are 0, and hw_head, fetch_ptr, unused_cnt and used_cnt are 0.
- R2: A fetch_go pulse with no fetch outstanding computes a count. The span is tail minus fetch_ptr when tail >= fetch_ptr, and ring length minus fetch_ptr otherwise. The count is that span limited to DEPTH minus used_cnt minus unused_cnt. A nonzero count raises fetch_req on the next clock edge, with that count on fetch_cnt and the start index on fetch_ptr. A zero count raises no request.
- R3: On a fetch acknowledge, unused_cnt grows by the fetched count and fetch_ptr advances by it. A fetch_ptr equal to the ring length becomes 0.
- R4: While a request is outstanding, further go pulses are ignored, and the request and its fields stay unchanged until acknowledged.
- R5: Each dp_done pulse lowers unused_cnt by one and raises used_cnt by one. When unused_cnt is 0 the pulse is ignored.
- R6: With a wb_mask of 0, a writeback covers all used entries. With a nonzero low-ones mask it covers used_cnt minus ((hw_head + used_cnt) AND mask), so the write ends on a mask+1 boundary. A result of 0 or less raises no request. A request appears one clock edge after wb_go, with the start index on hw_head.
- R7: When hw_head plus the writeback count reaches or passes the ring length, the count becomes ring length minus hw_head and wb_more is 1.
- R8: On a writeback acknowledge, used_cnt drops by the count and hw_head advances by it. The ring length is subtracted when the result is at or above it. head_upd pulses for exactly one cycle with the new hw_head.
- R9: After an acknowledge with wb_more set, the engine evaluates a further writeback with the same mask on the next edge, without any wb_go.
- R10: A length or head write while used_cnt is nonzero or any request is outstanding is discarded, and ring_err pulses for one cycle.
- R11: A length or head write with no used entries and nothing outstanding is applied, clears unused_cnt and used_cnt, and sets fetch_ptr to 0.
- R12: cfg_reset clears unused_cnt, used_cnt and fetch_ptr and drops any outstanding request. A later acknowledge then has no effect.
- R13: A tail write is accepted at any time and changes neither hw_head nor the entry counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_len_we | input | 1 | Ring length write strobe |
| cfg_len | input | PTR_W | Ring length in descriptors |
| cfg_head_we | input | 1 | Head write strobe |
| cfg_head | input | PTR_W | New head index |
| cfg_tail_we | input | 1 | Tail write strobe |
| cfg_tail | input | PTR_W | New tail index |
| cfg_reset | input | 1 | Cache reset strobe |
| fetch_go | input | 1 | Request a descriptor fetch |
| wb_go | input | 1 | Request a writeback |
| wb_mask | input | MASK_W | Writeback alignment mask |
| dp_done | input | 1 | Datapath finished one descriptor |
| fetch_req | output | 1 | Fetch request outstanding |
| fetch_ptr | output | PTR_W | Fetch pointer, start of fetch |
| fetch_cnt | output | CNT_W | Descriptors to fetch |
| fetch_ack | input | 1 | Fetch served |
| wb_req | output | 1 | Writeback request outstanding |
| wb_cnt | output | CNT_W | Descriptors to write back |
| wb_more | output | 1 | Writeback clipped at ring end |
| wb_ack | input | 1 | Writeback served |
| hw_head | output | PTR_W | Hardware head, start of writeback |
| head_upd | output | 1 | One-cycle pulse on head change |
| unused_cnt | output | CNT_W | Fetched, unconsumed entries |
| used_cnt | output | CNT_W | Completed, unwritten entries |
| ring_err | output | 1 | Rejected ring change pulse |

## Verification
The hardest state to reach is a writeback clipped at the ring end that leaves a remainder. That needs the head programmed close to the ring length, entries fetched from a different point, and enough completions to push the writeback past the end. The follow-up writeback must then be observed on the edge after the acknowledge. Directed sequences set this up, including the case of an exact landing on the ring end, where the follow-up finds nothing to write. A long random mix of fetches, completions, masked writebacks, tail moves and ring changes then drives the pointers across the wrap many times, checked against a reference model in the bench.

// File: rtl/desc_ring_pkg.sv
package desc_ring_pkg;

    // Default geometry shared by the engine and its helpers
    parameter int unsigned DEF_PTR_W  = 8;
    parameter int unsigned DEF_DEPTH  = 8;
    parameter int unsigned DEF_MASK_W = 4;

    // Width needed to count 0..depth inclusive
    function automatic int unsigned cnt_width(input int unsigned depth);
        return $clog2(depth + 1);
    endfunction

endpackage

// File: rtl/desc_fetch_calc.sv
module desc_fetch_calc #(
    parameter int unsigned PTR_W = 8,
    parameter int unsigned DEPTH = 8,
    parameter int unsigned CNT_W = 4
) (
    input  logic [PTR_W-1:0] len,
    input  logic [PTR_W-1:0] tail,
    input  logic [PTR_W-1:0] fptr,
    input  logic [CNT_W-1:0] unused,
    input  logic [CNT_W-1:0] used,
    output logic [CNT_W-1:0] cnt
);
    localparam int unsigned XW = PTR_W + 1;

    logic [XW-1:0] span_x;
    logic [XW-1:0] room_x;
    logic [XW-1:0] pick_x;

    always_comb begin
        // never cross the wrap point in one burst
        if (tail >= fptr) begin
            span_x = {1'b0, tail} - {1'b0, fptr};
        end else begin
            span_x = {1'b0, len} - {1'b0, fptr};
        end
        room_x = XW'(DEPTH) - XW'(used) - XW'(unused);
        pick_x = (span_x < room_x) ? span_x : room_x;
        cnt    = CNT_W'(pick_x);
    end

endmodule

// File: rtl/desc_wb_calc.sv
module desc_wb_calc #(
    parameter int unsigned PTR_W  = 8,
    parameter int unsigned CNT_W  = 4,
    parameter int unsigned MASK_W = 4
) (
    input  logic [PTR_W-1:0]  len,
    input  logic [PTR_W-1:0]  head,
    input  logic [CNT_W-1:0]  used,
    input  logic [MASK_W-1:0] mask,
    output logic [CNT_W-1:0]  cnt,
    output logic              more
);
    localparam int unsigned XW = PTR_W + 1;

    logic [XW-1:0] used_x;
    logic [XW-1:0] end_x;
    logic [XW-1:0] part_x;
    logic [XW-1:0] base_x;
    logic [XW-1:0] cnt_x;

    always_comb begin
        used_x = XW'(used);
        end_x  = {1'b0, head} + used_x;
        // entries past the last aligned boundary stay for later
        part_x = end_x & XW'(mask);
        base_x = (used_x > part_x) ? (used_x - part_x) : '0;
        cnt_x  = base_x;
        more   = 1'b0;
        if ((base_x != '0) && (({1'b0, head} + base_x) >= {1'b0, len})) begin
            cnt_x = {1'b0, len} - {1'b0, head};
            more  = 1'b1;
        end
        cnt = CNT_W'(cnt_x);
    end

endmodule

// File: rtl/desc_ring_engine.sv
module desc_ring_engine
    import desc_ring_pkg::*;
#(
    parameter int unsigned PTR_W  = DEF_PTR_W,
    parameter int unsigned DEPTH  = DEF_DEPTH,
    parameter int unsigned MASK_W = DEF_MASK_W,
    parameter int unsigned CNT_W  = cnt_width(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_len_we,
    input  logic [PTR_W-1:0]  cfg_len,
    input  logic              cfg_head_we,
    input  logic [PTR_W-1:0]  cfg_head,
    input  logic              cfg_tail_we,
    input  logic [PTR_W-1:0]  cfg_tail,
    input  logic              cfg_reset,
    input  logic              fetch_go,
    input  logic              wb_go,
    input  logic [MASK_W-1:0] wb_mask,
    input  logic              dp_done,
    output logic              fetch_req,
    output logic [PTR_W-1:0]  fetch_ptr,
    output logic [CNT_W-1:0]  fetch_cnt,
    input  logic              fetch_ack,
    output logic              wb_req,
    output logic [CNT_W-1:0]  wb_cnt,
    output logic              wb_more,
    input  logic              wb_ack,
    output logic [PTR_W-1:0]  hw_head,
    output logic              head_upd,
    output logic [CNT_W-1:0]  unused_cnt,
    output logic [CNT_W-1:0]  used_cnt,
    output logic              ring_err
);
    localparam int unsigned XW = PTR_W + 1;

    typedef struct packed {
        logic [PTR_W-1:0]  len;
        logic [PTR_W-1:0]  tail;
        logic [PTR_W-1:0]  head;
        logic [PTR_W-1:0]  fptr;
        logic [CNT_W-1:0]  unused;
        logic [CNT_W-1:0]  used;
        logic              fpend;
        logic [CNT_W-1:0]  fcnt;
        logic              wpend;
        logic [CNT_W-1:0]  wcnt;
        logic              wmore;
        logic [MASK_W-1:0] wmask;
        logic              follow;
        logic              head_upd;
        logic              err;
    } eng_state_t;

    eng_state_t state_d, state_q;

    logic [CNT_W-1:0]  fcalc_cnt;
    logic [CNT_W-1:0]  wcalc_cnt;
    logic              wcalc_more;
    logic [MASK_W-1:0] mask_sel;
    logic              fetch_fin;
    logic              wb_fin;
    logic              take_done;
    logic              wb_trig;
    logic              ring_wr;
    logic              busy;
    logic [XW-1:0]     fsum_x;
    logic [XW-1:0]     hsum_x;

    assign mask_sel = wb_go ? wb_mask : state_q.wmask;

    desc_fetch_calc #(
        .PTR_W (PTR_W),
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) i_fetch_calc (
        .len    (state_q.len),
        .tail   (state_q.tail),
        .fptr   (state_q.fptr),
        .unused (state_q.unused),
        .used   (state_q.used),
        .cnt    (fcalc_cnt)
    );

    desc_wb_calc #(
        .PTR_W  (PTR_W),
        .CNT_W  (CNT_W),
        .MASK_W (MASK_W)
    ) i_wb_calc (
        .len  (state_q.len),
        .head (state_q.head),
        .used (state_q.used),
        .mask (mask_sel),
        .cnt  (wcalc_cnt),
        .more (wcalc_more)
    );

    always_comb begin
        state_d          = state_q;
        state_d.head_upd = 1'b0;
        state_d.err      = 1'b0;
        state_d.follow   = 1'b0;

        fetch_fin = state_q.fpend & fetch_ack;
        wb_fin    = state_q.wpend & wb_ack;
        take_done = dp_done & (state_q.unused != '0);
        wb_trig   = wb_go | state_q.follow;
        ring_wr   = cfg_len_we | cfg_head_wr_w();
        busy      = (state_q.used != '0) | state_q.fpend | state_q.wpend;
        fsum_x    = {1'b0, state_q.fptr} + XW'(state_q.fcnt);
        hsum_x    = {1'b0, state_q.head} + XW'(state_q.wcnt);
        if (hsum_x >= {1'b0, state_q.len}) begin
            hsum_x = hsum_x - {1'b0, state_q.len};
        end

        // entry bookkeeping: fill, consume, drain
        state_d.unused = state_q.unused
                       + (fetch_fin ? state_q.fcnt : '0)
                       - CNT_W'(take_done);
        state_d.used   = state_q.used
                       + CNT_W'(take_done)
                       - (wb_fin ? state_q.wcnt : '0);

        if (fetch_fin) begin
            state_d.fpend = 1'b0;
            state_d.fptr  = (fsum_x == {1'b0, state_q.len}) ? '0 : fsum_x[PTR_W-1:0];
        end

        if (wb_fin) begin
            state_d.wpend    = 1'b0;
            state_d.head     = hsum_x[PTR_W-1:0];
            state_d.head_upd = 1'b1;
            state_d.follow   = state_q.wmore;
            state_d.wmore    = 1'b0;
        end

        // new requests, one outstanding of each kind
        if (fetch_go && !state_q.fpend && (fcalc_cnt != '0)) begin
            state_d.fpend = 1'b1;
            state_d.fcnt  = fcalc_cnt;
        end

        if (wb_trig && !state_q.wpend && (wcalc_cnt != '0)) begin
            state_d.wpend = 1'b1;
            state_d.wcnt  = wcalc_cnt;
            state_d.wmore = wcalc_more;
            state_d.wmask = mask_sel;
        end

        if (cfg_tail_we) begin
            state_d.tail = cfg_tail;
        end

        if (ring_wr) begin
            if (busy) begin
                state_d.err = 1'b1;
            end else begin
                if (cfg_len_we) begin
                    state_d.len = cfg_len;
                end
                if (cfg_head_we) begin
                    state_d.head = cfg_head;
                end
                state_d.unused = '0;
                state_d.used   = '0;
                state_d.fptr   = '0;
                state_d.fpend  = 1'b0;
                state_d.wpend  = 1'b0;
                state_d.wmore  = 1'b0;
                state_d.follow = 1'b0;
            end
        end

        if (cfg_reset) begin
            state_d.unused = '0;
            state_d.used   = '0;
            state_d.fptr   = '0;
            state_d.fpend  = 1'b0;
            state_d.wpend  = 1'b0;
            state_d.wmore  = 1'b0;
            state_d.follow = 1'b0;
            state_d.err    = 1'b0;
            state_d.len    = state_q.len;
            state_d.head   = state_q.head;
        end
    end

    function automatic logic cfg_head_wr_w();
        return cfg_head_we;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign fetch_req  = state_q.fpend;
    assign fetch_ptr  = state_q.fptr;
    assign fetch_cnt  = state_q.fcnt;
    assign wb_req     = state_q.wpend;
    assign wb_cnt     = state_q.wcnt;
    assign wb_more    = state_q.wmore;
    assign hw_head    = state_q.head;
    assign head_upd   = state_q.head_upd;
    assign unused_cnt = state_q.unused;
    assign used_cnt   = state_q.used;
    assign ring_err   = state_q.err;

    // R2
    fetch_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.fpend |-> ({1'b0, state_q.fptr} + XW'(state_q.fcnt)) <= {1'b0, state_q.len});

    // R3
    fetch_ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.len != '0) |-> (state_q.fptr < state_q.len));

    // R4
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.fpend && !fetch_ack && !cfg_reset)
        |=> (state_q.fpend && $stable(state_q.fcnt) && $stable(state_q.fptr)));

    // R5
    occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (XW'(state_q.unused) + XW'(state_q.used)) <= XW'(DEPTH));

    // R7
    wb_more_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.wpend && state_q.wmore)
        |-> (({1'b0, state_q.head} + XW'(state_q.wcnt)) == {1'b0, state_q.len}));

    // R10
    ring_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_len_we || cfg_head_we) && state_q.fpend && !cfg_reset) |=> ring_err);

    // R8
    head_upd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        head_upd |=> !head_upd);

endmodule

// File: tb/test_desc_ring_engine.sv
module test_desc_ring_engine;
    localparam int unsigned PTR_W  = 8;
    localparam int unsigned DEPTH  = 8;
    localparam int unsigned MASK_W = 4;
    localparam int unsigned CNT_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_len_we = 1'b0;
    logic [PTR_W-1:0]  cfg_len = '0;
    logic              cfg_head_we = 1'b0;
    logic [PTR_W-1:0]  cfg_head = '0;
    logic              cfg_tail_we = 1'b0;
    logic [PTR_W-1:0]  cfg_tail = '0;
    logic              cfg_reset = 1'b0;
    logic              fetch_go = 1'b0;
    logic              wb_go = 1'b0;
    logic [MASK_W-1:0] wb_mask = '0;
    logic              dp_done = 1'b0;
    logic              fetch_req;
    logic [PTR_W-1:0]  fetch_ptr;
    logic [CNT_W-1:0]  fetch_cnt;
    logic              fetch_ack = 1'b0;
    logic              wb_req;
    logic [CNT_W-1:0]  wb_cnt;
    logic              wb_more;
    logic              wb_ack = 1'b0;
    logic [PTR_W-1:0]  hw_head;
    logic              head_upd;
    logic [CNT_W-1:0]  unused_cnt;
    logic [CNT_W-1:0]  used_cnt;
    logic              ring_err;

    always #5 clk = ~clk;

    desc_ring_engine #(
        .PTR_W  (PTR_W),
        .DEPTH  (DEPTH),
        .MASK_W (MASK_W),
        .CNT_W  (CNT_W)
    ) i_desc_ring_engine (
        .clk (clk), .rst_n (rst_n),
        .cfg_len_we (cfg_len_we), .cfg_len (cfg_len),
        .cfg_head_we (cfg_head_we), .cfg_head (cfg_head),
        .cfg_tail_we (cfg_tail_we), .cfg_tail (cfg_tail),
        .cfg_reset (cfg_reset), .fetch_go (fetch_go),
        .wb_go (wb_go), .wb_mask (wb_mask), .dp_done (dp_done),
        .fetch_req (fetch_req), .fetch_ptr (fetch_ptr), .fetch_cnt (fetch_cnt),
        .fetch_ack (fetch_ack), .wb_req (wb_req), .wb_cnt (wb_cnt),
        .wb_more (wb_more), .wb_ack (wb_ack), .hw_head (hw_head),
        .head_upd (head_upd), .unused_cnt (unused_cnt), .used_cnt (used_cnt),
        .ring_err (ring_err)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // reference model
    int m_len = 0, m_tail = 0, m_head = 0, m_fptr = 0, m_unused = 0, m_used = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic int exp_fetch();
        int span, room;
        span = (m_tail >= m_fptr) ? (m_tail - m_fptr) : (m_len - m_fptr);
        room = DEPTH - m_used - m_unused;
        return (span < room) ? span : room;
    endfunction

    task automatic exp_wb(input int mask, output int cnt, output int more);
        int part;
        part = (m_head + m_used) & mask;
        cnt  = (m_used > part) ? (m_used - part) : 0;
        more = 0;
        if (cnt > 0 && (m_head + cnt) >= m_len) begin
            cnt  = m_len - m_head;
            more = 1;
        end
    endtask

    task automatic do_fetch(input bit hold_test);
        int e;
        e = exp_fetch();
        fetch_go = 1'b1;
        tick();
        fetch_go = 1'b0;
        if (e == 0) begin
            chk("R2 zero-count fetch_req", int'(fetch_req), 0);
            return;
        end
        chk("R2 fetch_req", int'(fetch_req), 1);
        chk("R2 fetch_cnt", int'(fetch_cnt), e);
        chk("R2 fetch_ptr", int'(fetch_ptr), m_fptr);
        if (hold_test) begin
            fetch_go = 1'b1;
            tick();
            fetch_go = 1'b0;
            chk("R4 fetch_req held", int'(fetch_req), 1);
            chk("R4 fetch_cnt held", int'(fetch_cnt), e);
        end
        fetch_ack = 1'b1;
        tick();
        fetch_ack = 1'b0;
        m_unused += e;
        m_fptr += e;
        if (m_fptr == m_len) m_fptr = 0;
        chk("R3 unused_cnt", int'(unused_cnt), m_unused);
        chk("R3 fetch_ptr", int'(fetch_ptr), m_fptr);
        chk("R3 fetch_req low", int'(fetch_req), 0);
    endtask

    task automatic do_done();
        dp_done = 1'b1;
        tick();
        dp_done = 1'b0;
        if (m_unused > 0) begin
            m_unused--;
            m_used++;
        end
        chk("R5 unused_cnt", int'(unused_cnt), m_unused);
        chk("R5 used_cnt", int'(used_cnt), m_used);
    endtask

    task automatic do_wb(input int mask);
        int cnt, more;
        string tag;
        exp_wb(mask, cnt, more);
        wb_go = 1'b1;
        wb_mask = MASK_W'(mask);
        tick();
        wb_go = 1'b0;
        tag = "R6";
        while (1) begin
            if (cnt == 0) begin
                chk({tag, " no wb_req"}, int'(wb_req), 0);
                break;
            end
            chk({tag, " wb_req"}, int'(wb_req), 1);
            chk({tag, " wb_cnt"}, int'(wb_cnt), cnt);
            chk("R7 wb_more", int'(wb_more), more);
            chk({tag, " start hw_head"}, int'(hw_head), m_head);
            wb_ack = 1'b1;
            tick();
            wb_ack = 1'b0;
            m_used -= cnt;
            m_head += cnt;
            if (m_head >= m_len) m_head -= m_len;
            chk("R8 hw_head", int'(hw_head), m_head);
            chk("R8 used_cnt", int'(used_cnt), m_used);
            chk("R8 head_upd", int'(head_upd), 1);
            if (more == 0) break;
            tick();
            exp_wb(mask, cnt, more);
            tag = "R9";
        end
    endtask

    task automatic do_ring(input int len, input int head);
        bit busy;
        busy = (m_used != 0);
        cfg_len_we = 1'b1;  cfg_len = PTR_W'(len);
        cfg_head_we = 1'b1; cfg_head = PTR_W'(head);
        tick();
        cfg_len_we = 1'b0; cfg_head_we = 1'b0;
        if (busy) begin
            chk("R10 ring_err", int'(ring_err), 1);
            chk("R10 hw_head kept", int'(hw_head), m_head);
            chk("R10 used_cnt kept", int'(used_cnt), m_used);
        end else begin
            m_len = len; m_head = head; m_fptr = 0; m_unused = 0; m_used = 0;
            chk("R11 ring_err", int'(ring_err), 0);
            chk("R11 unused_cnt", int'(unused_cnt), 0);
            chk("R11 used_cnt", int'(used_cnt), 0);
            chk("R11 fetch_ptr", int'(fetch_ptr), 0);
            chk("R11 hw_head", int'(hw_head), head);
        end
    endtask

    task automatic do_tail(input int t);
        cfg_tail_we = 1'b1;
        cfg_tail = PTR_W'(t);
        tick();
        cfg_tail_we = 1'b0;
        m_tail = t;
        chk("R13 hw_head", int'(hw_head), m_head);
        chk("R13 unused_cnt", int'(unused_cnt), m_unused);
        chk("R13 used_cnt", int'(used_cnt), m_used);
    endtask

    task automatic do_reset();
        cfg_reset = 1'b1;
        tick();
        cfg_reset = 1'b0;
        m_unused = 0; m_used = 0; m_fptr = 0;
        chk("R12 unused_cnt", int'(unused_cnt), 0);
        chk("R12 used_cnt", int'(used_cnt), 0);
        chk("R12 fetch_ptr", int'(fetch_ptr), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7715));
        tick();
        tick();
        rst_n = 1'b1;
        tick();
        // R1
        chk("R1 fetch_req", int'(fetch_req), 0);
        chk("R1 wb_req", int'(wb_req), 0);
        chk("R1 head_upd", int'(head_upd), 0);
        chk("R1 ring_err", int'(ring_err), 0);
        chk("R1 hw_head", int'(hw_head), 0);
        chk("R1 fetch_ptr", int'(fetch_ptr), 0);
        chk("R1 unused_cnt", int'(unused_cnt), 0);
        chk("R1 used_cnt", int'(used_cnt), 0);

        // basic fill, cap and zero-count
        do_ring(20, 0);
        do_tail(5);
        do_fetch(1'b0);
        do_fetch(1'b0);
        do_tail(18);
        do_fetch(1'b1);
        for (int i = 0; i < 9; i++) do_done();
        do_wb(3);
        do_fetch(1'b0);
        for (int i = 0; i < 5; i++) do_done();
        do_wb(3);

        // clip at ring end with a follow-up writeback
        do_reset();
        do_wb(0);
        do_ring(20, 17);
        do_tail(6);
        do_fetch(1'b0);
        for (int i = 0; i < 6; i++) do_done();
        do_wb(0);

        // exact landing on the ring end: follow-up finds nothing
        do_reset();
        do_ring(20, 17);
        do_tail(3);
        do_fetch(1'b0);
        for (int i = 0; i < 3; i++) do_done();
        do_wb(0);

        // fetch wraps back to zero
        do_ring(10, 0);
        do_tail(7);
        do_fetch(1'b0);
        for (int i = 0; i < 7; i++) do_done();
        do_wb(0);
        do_tail(2);
        do_fetch(1'b0);

        // ring change refused while a fetch is outstanding
        fetch_go = 1'b1;
        tick();
        fetch_go = 1'b0;
        chk("R2 fetch_req before busy write", int'(fetch_req), 1);
        cfg_len_we = 1'b1; cfg_len = 8'd30;
        tick();
        cfg_len_we = 1'b0;
        chk("R10 ring_err on busy write", int'(ring_err), 1);
        chk("R10 fetch_req kept", int'(fetch_req), 1);
        tick();
        chk("R10 ring_err one cycle", int'(ring_err), 0);
        begin
            int e2;
            e2 = exp_fetch();
            fetch_ack = 1'b1;
            tick();
            fetch_ack = 1'b0;
            m_unused += e2;
            m_fptr += e2;
            if (m_fptr == m_len) m_fptr = 0;
            chk("R3 fetch after refused write", int'(unused_cnt), m_unused);
        end

        // cache reset drops an outstanding request; late ack ignored
        do_reset();
        do_tail(6);
        fetch_go = 1'b1;
        tick();
        fetch_go = 1'b0;
        chk("R2 fetch_req before reset", int'(fetch_req), 1);
        do_reset();
        chk("R12 fetch_req dropped", int'(fetch_req), 0);
        fetch_ack = 1'b1;
        tick();
        fetch_ack = 1'b0;
        chk("R12 stray ack unused_cnt", int'(unused_cnt), 0);
        chk("R12 stray ack fetch_ptr", int'(fetch_ptr), 0);

        // random mix
        for (int it = 0; it < 600; it++) begin
            int op;
            op = int'($urandom % 8);
            case (op)
                0, 1: do_fetch(bit'($urandom % 2));
                2, 3, 4: do_done();
                5: begin
                    int mk;
                    mk = (1 << ($urandom % 4)) - 1;
                    do_wb(mk);
                end
                6: do_tail(int'($urandom % m_len));
                default: begin
                    int nl;
                    if (m_used == 0) begin
                        nl = 4 + int'($urandom % 28);
                        do_ring(nl, int'($urandom % nl));
                        do_tail(int'($urandom % nl));
                    end else begin
                        do_ring(m_len, m_head);
                    end
                end
            endcase
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule